// File: doc/BRIEF.md
# Thirty-Five Cent Drink Dispenser Controller

This block is the control state machine of a drink dispenser that charges 35 cents. A customer presents one coin at a time on three coin lines (five, ten and twenty-five cents) and presses a confirm button. Each confirmed coin adds to the credit. The credit is held internally as a count of nickels, from 0 to 11.

While the credit is under the price, the outputs stay quiet. When a confirmed coin brings the credit to 35 cents or more, the machine enters one of five terminal states, one for each total from 35 to 55 cents. In a terminal state it raises the dispense output and gives the change owed as a count of nickels. It stays there until the next confirmed coin. That coin is not added to the old total: it becomes the first coin of a new purchase.

The confirm button is asynchronous. It passes through a two-flop synchronizer, and the machine acts only on its rising edge. A coin is credited three clock edges after the button rises.

Top module: `vend_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is applied, the credit is cleared to zero and both outputs are low.
- R2: A confirmed coin adds its value to the credit: `coin_nickel` adds 5 cents, `coin_dime` adds 10 cents and `coin_quarter` adds 25 cents.
- R3: A coin is credited only once per press, on the third rising clock edge after `push_btn` rises. Holding the button down credits nothing further.
- R4: At a button rising edge, a press is ignored if no coin line is high, or if two or more coin lines are high.
- R5: While the credit is below 35 cents, `dispense` is low and `change_nickels` is 0.
- R6: When the credit reaches 35, 40, 45, 50 or 55 cents, `dispense` is high and `change_nickels` holds the change in nickels (0, 1, 2, 3 or 4 respectively).
- R7: A terminal state holds its outputs until the next confirmed coin. That coin starts a new purchase with a credit equal to its own value alone.
- R8: Coin lines that change while no button edge occurs have no effect on the credit or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | Five-cent coin is presented |
| coin_dime | input | 1 | Ten-cent coin is presented |
| coin_quarter | input | 1 | Twenty-five-cent coin is presented |
| push_btn | input | 1 | Asynchronous confirm button |
| dispense | output | 1 | High while a paid purchase is being served |
| change_nickels | output | 3 | Change owed, as a count of nickels; valid while dispense is high |

## Verification
The assertions check four rules on every cycle:
- change is zero whenever nothing is dispensed, and never exceeds four nickels;
- the credit changes only on a button edge;
- a terminal state keeps stable outputs until a single-coin press arrives, and that press always leaves the terminal state;
- reset clears the outputs.

Other behaviours need the bench's scenarios, because a credit below the price is visible only through later results. These include:
- the exact value each coin adds;
- that a rejected press (no coin or several coins) leaves the total untouched;
- that a held button counts once;
- that a coin after a sale starts from zero.

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int PRICE   = 7,
  parameter int V_NICK  = 1,
  parameter int V_DIME  = 2,
  parameter int V_QUART = 5,
  parameter int CW      = 4,
  parameter int CHG_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coin_nickel,
  input  logic             coin_dime,
  input  logic             coin_quarter,
  input  logic             push_btn,
  output logic             dispense,
  output logic [CHG_W-1:0] change_nickels
);

  logic [2:0]    btn_sh;
  logic [CW-1:0] credit;
  logic [CW-1:0] coin_val;
  logic [CW-1:0] base;
  logic [2:0]    coins;
  logic          press;
  logic          one_coin;

  always_ff @(posedge clk) begin
    if (rst) btn_sh <= '0;
    else     btn_sh <= {btn_sh[1:0], push_btn};
  end

  assign press    = btn_sh[1] & ~btn_sh[2];
  assign coins    = {coin_quarter, coin_dime, coin_nickel};
  assign one_coin = $onehot(coins);

  always_comb begin
    case (coins)
      3'b001:  coin_val = CW'(V_NICK);
      3'b010:  coin_val = CW'(V_DIME);
      3'b100:  coin_val = CW'(V_QUART);
      default: coin_val = '0;
    endcase
  end

  assign dispense = (credit >= CW'(PRICE));
  assign base     = dispense ? '0 : credit;

  always_ff @(posedge clk) begin
    if (rst)                   credit <= '0;
    else if (press && one_coin) credit <= base + coin_val;
  end

  assign change_nickels = dispense ? CHG_W'(credit - CW'(PRICE)) : '0;

endmodule

module vend_ctrl_chk #(
  parameter int CW    = 4,
  parameter int CHG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             coin_nickel,
  input logic             coin_dime,
  input logic             coin_quarter,
  input logic             press,
  input logic [CW-1:0]    credit,
  input logic             dispense,
  input logic [CHG_W-1:0] change_nickels
);
  logic single;
  assign single = ($countones({coin_quarter, coin_dime, coin_nickel}) == 1);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!dispense && change_nickels == '0)); // R1
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst) !dispense |-> change_nickels == '0); // R5
  AST_CHANGE_BOUND: assert property (@(posedge clk) disable iff (rst) change_nickels <= CHG_W'(4)); // R6
  AST_CREDIT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst) !press |=> $stable(credit)); // R8
  AST_TERM_HOLDS: assert property (@(posedge clk) disable iff (rst) (dispense && !(press && single)) |=> (dispense && $stable(change_nickels))); // R7
  AST_TERM_EXITS: assert property (@(posedge clk) disable iff (rst) (dispense && press && single) |=> !dispense); // R7
endmodule

bind vend_ctrl vend_ctrl_chk #(.CW(CW), .CHG_W(CHG_W)) u_chk (
  .clk(clk), .rst(rst), .coin_nickel(coin_nickel), .coin_dime(coin_dime),
  .coin_quarter(coin_quarter), .press(press), .credit(credit),
  .dispense(dispense), .change_nickels(change_nickels)
);

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic n = 1'b0, d = 1'b0, q = 1'b0, btn = 1'b0;
  logic dispense;
  logic [2:0] change_nickels;
  int checks = 0, fails = 0, credit = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vend_ctrl i_vend_ctrl (
    .clk(clk), .rst(rst), .coin_nickel(n), .coin_dime(d), .coin_quarter(q),
    .push_btn(btn), .dispense(dispense), .change_nickels(change_nickels)
  );

  function automatic int next_credit(int c, logic [2:0] cs);
    int base = (c >= 7) ? 0 : c;
    case (cs)
      3'b001:  return base + 1;
      3'b010:  return base + 2;
      3'b100:  return base + 5;
      default: return c;
    endcase
  endfunction

  task automatic check(string req);
    logic       ed = (credit >= 7);
    logic [2:0] ec = ed ? 3'(credit - 7) : 3'd0;
    checks++;
    if (dispense !== ed || change_nickels !== ec) begin
      fails++;
      $display("FAIL %s: dispense=%b change=%0d expected dispense=%b change=%0d",
               req, dispense, change_nickels, ed, ec);
    end
  endtask

  task automatic press(logic [2:0] cs, int hold, string req);
    {q, d, n} = cs;
    btn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    credit = next_credit(credit, cs);
    check(req);
    repeat (hold) @(posedge clk);
    @(negedge clk);
    check("R3 hold");
    btn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    {q, d, n} = 3'b000;
  endtask

  task automatic wiggle_coins();
    repeat (4) begin
      {q, d, n} = 3'($urandom_range(0, 7));
      @(negedge clk);
    end
    {q, d, n} = 3'b000;
    check("R8");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1");
    rst = 1'b0;
    @(negedge clk);
    check("R1");
    // R2 R6: seven nickels reach 35 exactly
    repeat (7) press(3'b001, 0, "R2 nickel");
    press(3'b100, 0, "R7 new purchase");
    press(3'b100, 0, "R6 fifty");
    // R4 rejected presses leave credit untouched
    press(3'b000, 0, "R4 none");
    press(3'b011, 0, "R4 two");
    press(3'b111, 0, "R4 three");
    press(3'b010, 1, "R7 from fifty");
    press(3'b010, 0, "R2 dime");
    press(3'b010, 0, "R2 dime");
    press(3'b100, 0, "R6 fifty-five");
    wiggle_coins();
    press(3'b100, 6, "R3 long hold");
    wiggle_coins();
    for (int i = 0; i < 300; i++) begin
      logic [2:0] cs;
      int r = $urandom_range(0, 9);
      if (r < 7) cs = 3'b001 << $urandom_range(0, 2);
      else       cs = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) wiggle_coins();
      press(cs, $urandom_range(0, 3), "R6 random");
    end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    credit = 0;
    check("R1 late reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule